// File: doc/BRIEF.md
# DS3 P-Bit Parity Error Counter

This block watches a received DS3 bit stream, one bit per clock, and counts the frames whose two P bits fail the parity check. The framer that feeds it marks each information bit and each of the two P-bit positions with a strobe, and it pulses a frame-end strobe on the last bit time of every frame. The block XORs the information bits of each frame. It holds that result and checks it against both P bits of the following frame. It also checks the two P bits against each other. A frame that fails either test adds one to a 16-bit internal count.

Software-facing logic pulses an update strobe. On that strobe the internal count is copied into a 16-bit holding value, shown as two bytes, and the internal count starts again from zero. An out-of-frame input and a control input decide whether errors are counted while alignment is lost. An E3-mode input forces the count to zero, because the P-bit check has no meaning on E3 streams.

Top module: `pbit_parity_monitor`

## Requirements
- R1: After reset both bytes of the holding value read zero, and the internal count is zero.
- R2: The holding value changes only on a clock where `update_stb` is high. It then takes the internal count as it stood before that edge.
- R3: A frame whose two P bits differ from each other adds one to the count. The first P bit is the bit sampled with `p1_stb`, and the second is the bit sampled with `p2_stb`, or `rx_bit` itself when `p2_stb` coincides with `frame_end`.
- R4: The reference parity is the XOR of every bit sampled with `info_stb` during the previous frame, including an information bit on the `frame_end` cycle. A frame whose two P bits are equal but differ from this parity adds one. A frame whose P bits equal it adds nothing.
- R5: One frame adds at most one to the count, even when both error conditions hold.
- R6: `update_stb` restarts the internal count. An error frame ending on the same clock as `update_stb` is not lost: the holding value excludes it and the new count starts at one.
- R7: The internal count saturates at 65535 and does not wrap.
- R8: While `oof` is high, error frames are ignored when `count_in_oof` is 0 and counted when it is 1.
- R9: The first frame that ends after reset, or after `oof` was last high, skips the comparison against the previous-frame parity. The comparison of the two P bits with each other still applies to that frame.
- R10: While `e3_mode` is high the internal count is held at zero and no frame adds to it, so an update latches zero.
- R11: `held_lo` carries bits 7:0 of the holding value and `held_hi` carries bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_bit | input | 1 | Received serial data bit |
| info_stb | input | 1 | `rx_bit` is an information bit |
| p1_stb | input | 1 | `rx_bit` is the first P bit |
| p2_stb | input | 1 | `rx_bit` is the second P bit |
| frame_end | input | 1 | Last bit time of the current frame |
| oof | input | 1 | Framer is out of frame |
| e3_mode | input | 1 | Line is E3; the count is forced to zero |
| count_in_oof | input | 1 | 1: keep counting while out of frame |
| update_stb | input | 1 | Latch the count and restart it |
| held_lo | output | 8 | Holding value, bits 7:0 |
| held_hi | output | 8 | Holding value, bits 15:8 |

## Verification
The update strobe and the end of an error frame can land on the same clock, so a clear and an increment meet in one edge. The bench provokes this by raising `update_stb` on the `frame_end` cycle of a P-mismatch frame, after two earlier error frames. It then reads the holding value, which must show 2. A second update must show 1, which proves the colliding frame went into the new interval and was neither lost nor counted twice. Saturation meets update in the same way: the count is driven to 65535 by back-to-back single-cycle error frames, and the latched value must read all ones rather than a wrapped value.

// File: rtl/pbpm_pkg.sv
// Package: shared widths and types for the P-bit parity monitor.
// Assumes the count width is a whole number of bytes.
package pbpm_pkg;
    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = CNT_W / BYTE_W;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // The two P bits of one frame as seen at the frame-end decision point
    typedef struct packed {
        logic first;
        logic second;
    } pbits_t;
endpackage

// File: rtl/pbpm_frame_check.sv
// Module: pbpm_frame_check
// Accumulates information-bit parity per frame, captures both P bits and,
// on the frame-end cycle, decides whether the frame is a parity error.
// Assumes strobes are one bit time wide and that the framer marks at most
// one P slot per cycle. A P slot may share the frame-end cycle; the bit is
// bypassed combinationally so single-cycle frames still judge correctly.
module pbpm_frame_check
    import pbpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic info_stb,
    input  logic p1_stb,
    input  logic p2_stb,
    input  logic frame_end,
    input  logic oof,
    input  logic e3_mode,
    input  logic count_in_oof,
    output logic frame_inc
);
    logic   run_par_q;
    logic   prev_par_q;
    logic   prev_ok_q;
    pbits_t pcap_q;
    pbits_t pnow;
    logic   frame_par;
    logic   pair_bad;
    logic   ref_bad;
    logic   count_gate;

    // Present P bits, with bypass for a P slot on the current cycle
    always_comb begin
        pnow.first  = p1_stb ? rx_bit : pcap_q.first;
        pnow.second = p2_stb ? rx_bit : pcap_q.second;
    end

    // Parity of this frame including an info bit on the frame-end cycle
    assign frame_par = run_par_q ^ (info_stb & rx_bit);

    // Running XOR of information bits, restarted at each frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_par_q <= 1'b0;
        else if (frame_end)
            run_par_q <= 1'b0;
        else if (info_stb)
            run_par_q <= run_par_q ^ rx_bit;
    end

    // Parity of the frame just finished, the reference for the next frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_par_q <= 1'b0;
        else if (frame_end)
            prev_par_q <= frame_par;
    end

    // Reference validity: lost while out of frame, earned by one whole frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_ok_q <= 1'b0;
        else if (oof)
            prev_ok_q <= 1'b0;
        else if (frame_end)
            prev_ok_q <= 1'b1;
    end

    // Capture registers for the two P-bit slots
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcap_q <= '0;
        else
            pcap_q <= pnow;
    end

    // Error decision: pair disagreement, or agreement against a bad reference
    always_comb begin
        pair_bad   = pnow.first ^ pnow.second;
        ref_bad    = prev_ok_q & (pnow.first ^ prev_par_q);
        count_gate = !e3_mode && (!oof || count_in_oof);
        frame_inc  = frame_end && count_gate && (pair_bad || ref_bad);
    end
endmodule

// File: rtl/pbpm_err_count.sv
// Module: pbpm_err_count
// Saturating error counter. Restart on update keeps an increment from the
// same cycle; a force-zero input holds the count at zero.
// Assumes inc is at most one pulse per cycle.
module pbpm_err_count
    import pbpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic restart,
    input  logic force_zero,
    output cnt_t cnt
);
    localparam cnt_t CNT_MAX = {CNT_W{1'b1}};
    localparam cnt_t CNT_ONE = cnt_t'(1);

    logic at_max;
    assign at_max = (cnt == CNT_MAX);

    // Count step: zero-force, restart with carry-in, or saturating increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (force_zero)
            cnt <= '0;
        else if (restart)
            cnt <= inc ? CNT_ONE : '0;
        else if (inc && !at_max)
            cnt <= cnt + CNT_ONE;
    end
endmodule

// File: rtl/pbpm_hold_reg.sv
// Module: pbpm_hold_reg
// Holding register that snapshots the count on a load strobe and presents
// it split into bytes, least significant byte at index zero.
module pbpm_hold_reg
    import pbpm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  cnt_t                din,
    output byte_t [N_BYTES-1:0] bytes_o
);
    cnt_t held_q;

    // Snapshot of the count taken on each load strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (load)
            held_q <= din;
    end

    // Byte lanes of the held value
    for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
        assign bytes_o[b] = held_q[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/pbit_parity_monitor.sv
// Module: pbit_parity_monitor
// Top of the DS3 P-bit parity error counter: frame judge, saturating
// counter and byte-wide holding register. Assumes a framer supplies the
// position strobes and that the holding value is read as two bytes.
module pbit_parity_monitor
    import pbpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_bit,
    input  logic       info_stb,
    input  logic       p1_stb,
    input  logic       p2_stb,
    input  logic       frame_end,
    input  logic       oof,
    input  logic       e3_mode,
    input  logic       count_in_oof,
    input  logic       update_stb,
    output logic [7:0] held_lo,
    output logic [7:0] held_hi
);
    logic                frame_inc;
    cnt_t                cnt_q;
    byte_t [N_BYTES-1:0] lanes;

    pbpm_frame_check u_judge (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_bit       (rx_bit),
        .info_stb     (info_stb),
        .p1_stb       (p1_stb),
        .p2_stb       (p2_stb),
        .frame_end    (frame_end),
        .oof          (oof),
        .e3_mode      (e3_mode),
        .count_in_oof (count_in_oof),
        .frame_inc    (frame_inc)
    );

    pbpm_err_count u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (frame_inc),
        .restart    (update_stb),
        .force_zero (e3_mode),
        .cnt        (cnt_q)
    );

    pbpm_hold_reg u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (update_stb),
        .din     (cnt_q),
        .bytes_o (lanes)
    );

    assign held_lo = lanes[0];
    assign held_hi = lanes[1];
endmodule

// File: rtl/pbit_parity_monitor_chk.sv
// Module: pbit_parity_monitor_chk
// Temporal checks on the parity monitor, bound to the top module.
module pbit_parity_monitor_chk
    import pbpm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       update_stb,
    input logic       e3_mode,
    input logic       oof,
    input logic       count_in_oof,
    input logic       frame_inc,
    input cnt_t       cnt_q,
    input logic [7:0] held_lo,
    input logic [7:0] held_hi
);
    localparam cnt_t CMAX = {CNT_W{1'b1}};

    // R2
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !update_stb |=> $stable({held_hi, held_lo}));

    // R2
    held_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |=> ({held_hi, held_lo} == $past(cnt_q)));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (update_stb && !e3_mode) |=> (cnt_q == cnt_t'($past(frame_inc))));

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!update_stb && !e3_mode) |=>
            (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + cnt_t'(1)));

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CMAX && !update_stb && !e3_mode) |=> (cnt_q == CMAX));

    // R8
    oof_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oof && !count_in_oof) |-> !frame_inc);

    // R10
    e3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e3_mode |=> (cnt_q == '0));

    // R10
    e3_no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e3_mode |-> !frame_inc);
endmodule

bind pbit_parity_monitor pbit_parity_monitor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .update_stb   (update_stb),
    .e3_mode      (e3_mode),
    .oof          (oof),
    .count_in_oof (count_in_oof),
    .frame_inc    (frame_inc),
    .cnt_q        (cnt_q),
    .held_lo      (held_lo),
    .held_hi      (held_hi)
);

// File: tb/pbit_parity_monitor_test.sv
`timescale 1ns/1ps
module pbit_parity_monitor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0, info_stb = 1'b0, p1_stb = 1'b0, p2_stb = 1'b0;
    logic frame_end = 1'b0, oof = 1'b0, e3_mode = 1'b0, count_in_oof = 1'b0;
    logic update_stb = 1'b0;
    logic [7:0] held_lo, held_hi;
    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] got;

    always #2.5 clk = ~clk;

    pbit_parity_monitor uut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .info_stb(info_stb),
        .p1_stb(p1_stb), .p2_stb(p2_stb), .frame_end(frame_end), .oof(oof),
        .e3_mode(e3_mode), .count_in_oof(count_in_oof),
        .update_stb(update_stb), .held_lo(held_lo), .held_hi(held_hi)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one bit time, inputs change on the falling edge
    task automatic cyc(input logic d, input logic inf, input logic s1,
                       input logic s2, input logic fe, input logic up);
        rx_bit = d; info_stb = inf; p1_stb = s1; p2_stb = s2;
        frame_end = fe; update_stb = up;
        @(negedge clk);
        rx_bit = 1'b0; info_stb = 1'b0; p1_stb = 1'b0; p2_stb = 1'b0;
        frame_end = 1'b0; update_stb = 1'b0;
    endtask

    // Frame: P1 slot, P2 slot, eight info bits, last one ends the frame
    task automatic send_frame(input logic [7:0] info, input logic a, input logic b,
                              input logic upd_at_end);
        cyc(a, 0, 1, 0, 0, 0);
        cyc(b, 0, 0, 1, 0, 0);
        for (int i = 0; i < 8; i++)
            cyc(info[i], 1, 0, 0, i == 7, (i == 7) && upd_at_end);
    endtask

    // Update strobe, then read the two holding bytes
    task automatic read_held(output logic [15:0] v);
        cyc(0, 0, 0, 0, 0, 1);
        v = {held_hi, held_lo};
    endtask

    // Single-cycle error frames: P1 captured as 0, P2 as 1 on frame end
    task automatic fast_errors(input int n);
        cyc(0, 0, 1, 0, 0, 0);
        for (int i = 0; i < n; i++)
            cyc(1, 0, 0, 1, 1, 0);
    endtask

    task automatic t_reset;
        check("R1 reset holding", {held_hi, held_lo}, 16'h0000);
        read_held(got);
        check("R1 reset count", got, 16'h0000);
    endtask

    task automatic t_clean;
        send_frame(8'h03, 0, 0, 0);   // first frame: reference skipped
        send_frame(8'h07, 0, 0, 0);   // ref 0 ok; this parity 1
        send_frame(8'h00, 1, 1, 0);   // ref 1 ok
        send_frame(8'h80, 0, 0, 0);   // ref 0 ok; info on frame_end -> 1
        send_frame(8'h00, 1, 1, 0);   // ref 1 ok (R4 end-cycle bit)
        read_held(got);
        check("R4 R9 clean frames", got, 16'h0000);
        cyc(0, 0, 0, 0, 0, 0);
        check("R2 holding stable", {held_hi, held_lo}, 16'h0000);
    endtask

    task automatic t_pair;
        send_frame(8'h00, 1, 0, 0);
        send_frame(8'h00, 0, 1, 0);
        send_frame(8'h00, 1, 0, 0);
        read_held(got);
        check("R3 R5 P-bit pair mismatch", got, 16'd3);
    endtask

    task automatic t_ref;
        send_frame(8'h00, 0, 0, 0);
        read_held(got);               // discard
        send_frame(8'h01, 0, 0, 0);   // ref 0 ok, parity 1
        send_frame(8'h00, 0, 0, 0);   // ref 1 -> error
        send_frame(8'h00, 1, 1, 0);   // ref 0 -> error
        read_held(got);
        check("R4 reference parity mismatch", got, 16'd2);
    endtask

    task automatic t_collide;
        send_frame(8'h00, 1, 0, 0);
        send_frame(8'h00, 1, 0, 0);
        send_frame(8'h00, 1, 0, 1);   // error and update on one edge
        check("R6 holding excludes colliding frame", {held_hi, held_lo}, 16'd2);
        read_held(got);
        check("R6 colliding frame carried over", got, 16'd1);
    endtask

    task automatic t_oof;
        count_in_oof = 1'b0; oof = 1'b1;
        send_frame(8'h00, 1, 0, 0);
        send_frame(8'h00, 0, 1, 0);
        read_held(got);
        check("R8 ignored while out of frame", got, 16'd0);
        count_in_oof = 1'b1;
        send_frame(8'h00, 1, 0, 0);
        send_frame(8'h00, 0, 1, 0);
        read_held(got);
        check("R8 counted while out of frame", got, 16'd2);
        oof = 1'b0; count_in_oof = 1'b0;
    endtask

    task automatic t_realign;
        send_frame(8'h00, 0, 0, 0);
        read_held(got);
        oof = 1'b1; cyc(0, 0, 0, 0, 0, 0); oof = 1'b0;
        send_frame(8'h00, 1, 1, 0);   // would fail ref 0, skipped
        read_held(got);
        check("R9 first frame skips reference", got, 16'd0);
        send_frame(8'h00, 1, 1, 0);   // ref now 0 -> error
        read_held(got);
        check("R9 second frame uses reference", got, 16'd1);
        oof = 1'b1; cyc(0, 0, 0, 0, 0, 0); oof = 1'b0;
        send_frame(8'h00, 1, 0, 0);   // pair check still applies
        read_held(got);
        check("R9 pair check on first frame", got, 16'd1);
    endtask

    task automatic t_e3;
        send_frame(8'h00, 1, 0, 0);
        send_frame(8'h00, 1, 0, 0);
        e3_mode = 1'b1;
        cyc(0, 0, 0, 0, 0, 0);
        send_frame(8'h00, 1, 0, 0);
        send_frame(8'h00, 0, 1, 0);
        read_held(got);
        check("R10 E3 forces zero", got, 16'd0);
        e3_mode = 1'b0;
        read_held(got);
        check("R10 no carry from E3", got, 16'd0);
    endtask

    task automatic t_bytes;
        fast_errors(291);
        read_held(got);
        check("R11 low byte", {8'h00, held_lo}, 16'h0023);
        check("R11 high byte", {8'h00, held_hi}, 16'h0001);
    endtask

    task automatic t_saturate;
        fast_errors(65540);
        read_held(got);
        check("R7 saturate at all ones", got, 16'hFFFF);
        read_held(got);
        check("R6 restart after saturation", got, 16'h0000);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_pair();
        t_ref();
        t_collide();
        t_oof();
        t_realign();
        t_e3();
        t_bytes();
        t_saturate();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule